// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Controller

This block is the synchronous serial front end of a small three-wire EEPROM. It watches a chip-select, a serial clock and a serial data input. It waits for a start bit and then shifts in a two-bit opcode, an address and, for the write commands, a data word. It decodes seven commands: read, write, erase, enable, disable, erase-all and write-all. Read data and a ready/busy status leave on a single data-out pin. That pin has a separate output-enable, so the high-impedance state can be observed directly.

The storage is an internal byte array. An organization input chooses 16-bit or 8-bit words. Programming commands are held back by a write-enable latch that starts out cleared. Each accepted programming command starts a fixed-length busy period, counted in system clocks. The serial pins are synchronized into the system clock domain, and serial clock rising edges are detected there. The serial clock must therefore stay high and low for at least four system clocks each.

Top module: `mw_eeprom`

## Requirements
- R1: A frame begins only at a serial clock rise that sees both chip-select and data-in high. Leading zeros with chip-select high, and any activity while chip-select is low, have no effect.
- R2: With `org` high, words are 16 bits and addresses 6 bits. With `org` low, words are 8 bits and addresses 7 bits. In 16-bit mode, word n holds byte 2n as its upper half and byte 2n+1 as its lower half. Address and data are sent most significant bit first.
- R3: If chip-select drops before the last required bit of a command, the command has no effect and no busy period starts.
- R4: Once a command's last required bit has been transferred, further clock and data activity is ignored until chip-select goes low and a new start bit arrives.
- R5: After reset the write-enable latch is cleared, and write, erase, erase-all and write-all change nothing. Extended code 11 sets the latch and extended code 00 clears it. Opcodes after the start bit: 10 read, 01 write, 11 erase, 00 extended. An extended command's code is the first two address bits: 11 enable, 00 disable, 10 erase-all, 01 write-all.
- R6: In a read, the clock rise that takes the last address bit makes data-out drive a dummy zero. Each of the following rises then presents one data bit, MSB first.
- R7: Within three system clocks after chip-select falls, the output-enable is low.
- R8: After an accepted programming command, once chip-select goes low and then high again, data-out is driven low while busy and high once ready.
- R9: Erase sets the addressed word to all ones.
- R10: Write-all stores its data word in every location. Erase-all sets every location to all ones.
- R11: While busy, a start bit is not accepted and status stays on the output. A busy period lasts PROG_CYCLES system clocks.
- R12: After reset the output-enable is low and every byte of storage holds all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock |
| din | input | 1 | Serial data in |
| org | input | 1 | Word size select: 1 = 16-bit, 0 = 8-bit |
| dout | output | 1 | Serial data out (read data or ready status) |
| dout_oe | output | 1 | Output enable for dout; low means high impedance |

## Verification
Two functions can land in the same cycle. A programming busy period can still be running when a new start bit arrives. A chip-select drop can arrive just before the bit that would complete a command. The bench provokes the first by raising chip-select and clocking in a read frame right after a write. It passes only if the output keeps showing low status and the later read returns the written word. It provokes the second by cutting a write off ten data bits in. It passes only if no status is driven on the next chip-select and the word still reads as all ones.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADR, ST_DAT, ST_RD, ST_DONE
  } frame_st_t;

  typedef enum logic [2:0] {
    PG_NONE, PG_WRITE, PG_ERASE, PG_ERASE_ALL, PG_WRITE_ALL
  } prog_op_t;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_ERASE = 2'b11;
  localparam logic [1:0] OPC_EXT   = 2'b00;

  localparam logic [1:0] EXT_EN   = 2'b11;
  localparam logic [1:0] EXT_DIS  = 2'b00;
  localparam logic [1:0] EXT_ERAL = 2'b10;
  localparam logic [1:0] EXT_WRAL = 2'b01;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 5;
endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sck,
  input  logic din,
  output logic cs_q,
  output logic din_q,
  output logic sck_rise
);
  logic [2:0] pipe [STAGES];
  logic       sck_d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= 3'b000;
        else        pipe[0] <= {cs, sck, din};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[i] <= 3'b000;
        else        pipe[i] <= pipe[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= pipe[STAGES-1][1];
  end

  assign cs_q     = pipe[STAGES-1][2];
  assign din_q    = pipe[STAGES-1][0];
  assign sck_rise = pipe[STAGES-1][1] & ~sck_d;
endmodule

// File: rtl/mw_store.sv
module mw_store
  import mw_pkg::*;
#(
  parameter int ADR16_W     = 6,
  parameter int PROG_CYCLES = 200
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  org,
  input  logic [ADR16_W:0]      rd_adr,
  output logic [WORD_W-1:0]     rd_word,
  input  logic                  prog_req,
  input  prog_op_t              prog_op,
  input  logic [ADR16_W:0]      prog_adr,
  input  logic [WORD_W-1:0]     prog_data,
  output logic                  busy
);
  localparam int ADR8_W = ADR16_W + 1;
  localparam int NBYTES = 1 << ADR8_W;
  localparam int TW     = $clog2(PROG_CYCLES + 1);

  logic [BYTE_W-1:0]  mem [NBYTES];
  logic [TW-1:0]      tmr;
  logic [ADR16_W-1:0] rd_w16;
  logic [ADR16_W-1:0] pg_w16;
  logic [BYTE_W-1:0]  hi_val;
  logic [BYTE_W-1:0]  lo_val;

  assign rd_w16 = rd_adr[ADR16_W-1:0];
  assign pg_w16 = prog_adr[ADR16_W-1:0];

  always_comb begin
    if (org) rd_word = {mem[{rd_w16, 1'b0}], mem[{rd_w16, 1'b1}]};
    else     rd_word = {mem[rd_adr], 8'h00};
  end

  always_comb begin
    if (prog_op == PG_ERASE || prog_op == PG_ERASE_ALL) begin
      hi_val = 8'hFF;
      lo_val = 8'hFF;
    end else begin
      hi_val = org ? prog_data[15:8] : prog_data[7:0];
      lo_val = prog_data[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) mem[i] <= 8'hFF;
    end else if (prog_req) begin
      unique case (prog_op)
        PG_WRITE, PG_ERASE: begin
          if (org) begin
            mem[{pg_w16, 1'b0}] <= hi_val;
            mem[{pg_w16, 1'b1}] <= lo_val;
          end else begin
            mem[prog_adr] <= lo_val;
          end
        end
        PG_ERASE_ALL, PG_WRITE_ALL: begin
          for (int i = 0; i < NBYTES; i++)
            mem[i] <= (i % 2 == 0) ? hi_val : lo_val;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               tmr <= '0;
    else if (prog_req)        tmr <= TW'(PROG_CYCLES);
    else if (tmr != '0)       tmr <= tmr - 1'b1;
  end

  assign busy = (tmr != '0);
endmodule

// File: rtl/mw_frame.sv
module mw_frame
  import mw_pkg::*;
#(
  parameter int ADR16_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_q,
  input  logic               din_q,
  input  logic               sck_rise,
  input  logic               org,
  input  logic               busy,
  input  logic [WORD_W-1:0]  rd_word,
  output logic [ADR16_W:0]   rd_adr,
  output logic               prog_req,
  output prog_op_t           prog_op,
  output logic [ADR16_W:0]   prog_adr,
  output logic [WORD_W-1:0]  prog_data,
  output logic               wen,
  output frame_st_t          st,
  output logic               dout,
  output logic               dout_oe
);
  localparam int ADR8_W = ADR16_W + 1;

  logic [1:0]        opc;
  logic [CNT_W-1:0]  bitcnt;
  logic [ADR8_W-1:0] adr, adr_nx;
  logic [WORD_W-1:0] dat, dat_nx, shreg;
  logic              dout_r;
  logic              prog_flag;
  logic [CNT_W-1:0]  aw_last, dw_last, dw_len;
  logic [1:0]        ext_nx;

  always_comb begin
    aw_last = org ? CNT_W'(ADR16_W - 1) : CNT_W'(ADR8_W - 1);
    dw_last = org ? CNT_W'(WORD_W - 1)  : CNT_W'(BYTE_W - 1);
    dw_len  = org ? CNT_W'(WORD_W)      : CNT_W'(BYTE_W);
    adr_nx  = {adr[ADR8_W-2:0], din_q};
    dat_nx  = {dat[WORD_W-2:0], din_q};
    ext_nx  = org ? adr_nx[ADR16_W-1 -: 2] : adr_nx[ADR8_W-1 -: 2];
  end

  assign rd_adr = adr_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      opc       <= 2'b00;
      bitcnt    <= '0;
      adr       <= '0;
      dat       <= '0;
      shreg     <= '0;
      dout_r    <= 1'b0;
      prog_flag <= 1'b0;
      wen       <= 1'b0;
      prog_req  <= 1'b0;
      prog_op   <= PG_NONE;
      prog_adr  <= '0;
      prog_data <= '0;
    end else begin
      prog_req <= 1'b0;
      if (!cs_q) begin
        st     <= ST_IDLE;
        dout_r <= 1'b0;
      end else if (sck_rise) begin
        unique case (st)
          ST_IDLE: begin
            if (din_q && !busy) begin
              st        <= ST_OPC;
              bitcnt    <= '0;
              adr       <= '0;
              dat       <= '0;
              prog_flag <= 1'b0;
            end
          end
          ST_OPC: begin
            opc <= {opc[0], din_q};
            if (bitcnt == CNT_W'(1)) begin
              st     <= ST_ADR;
              bitcnt <= '0;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
          ST_ADR: begin
            adr <= adr_nx;
            if (bitcnt == aw_last) begin
              bitcnt <= '0;
              st     <= ST_DONE;
              unique case (opc)
                OPC_READ: begin
                  st     <= ST_RD;
                  shreg  <= rd_word;
                  dout_r <= 1'b0;
                end
                OPC_WRITE: st <= ST_DAT;
                OPC_ERASE: begin
                  if (wen) begin
                    prog_req  <= 1'b1;
                    prog_op   <= PG_ERASE;
                    prog_adr  <= adr_nx;
                    prog_flag <= 1'b1;
                  end
                end
                default: begin
                  unique case (ext_nx)
                    EXT_EN:   wen <= 1'b1;
                    EXT_DIS:  wen <= 1'b0;
                    EXT_ERAL: begin
                      if (wen) begin
                        prog_req  <= 1'b1;
                        prog_op   <= PG_ERASE_ALL;
                        prog_adr  <= adr_nx;
                        prog_flag <= 1'b1;
                      end
                    end
                    default:  st <= ST_DAT;
                  endcase
                end
              endcase
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
          ST_DAT: begin
            dat <= dat_nx;
            if (bitcnt == dw_last) begin
              st <= ST_DONE;
              if (wen) begin
                prog_req  <= 1'b1;
                prog_op   <= (opc == OPC_WRITE) ? PG_WRITE : PG_WRITE_ALL;
                prog_adr  <= adr;
                prog_data <= dat_nx;
                prog_flag <= 1'b1;
              end
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
          ST_RD: begin
            if (bitcnt == dw_len) begin
              st <= ST_DONE;
            end else begin
              dout_r <= shreg[WORD_W-1];
              shreg  <= {shreg[WORD_W-2:0], 1'b0};
              bitcnt <= bitcnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign dout_oe = cs_q && ((st == ST_RD) || (st == ST_IDLE && prog_flag));
  assign dout    = dout_oe && ((st == ST_RD) ? dout_r : !busy);
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int ADR16_W     = 6,
  parameter int PROG_CYCLES = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sck,
  input  logic din,
  input  logic org,
  output logic dout,
  output logic dout_oe
);
  logic              cs_q, din_q, sck_rise;
  logic              busy, prog_req, wen;
  prog_op_t          prog_op;
  frame_st_t         st;
  logic [ADR16_W:0]  rd_adr, prog_adr;
  logic [WORD_W-1:0] rd_word, prog_data;

  mw_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .din(din),
    .cs_q(cs_q), .din_q(din_q), .sck_rise(sck_rise)
  );

  mw_frame #(.ADR16_W(ADR16_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .din_q(din_q),
    .sck_rise(sck_rise), .org(org), .busy(busy), .rd_word(rd_word),
    .rd_adr(rd_adr), .prog_req(prog_req), .prog_op(prog_op),
    .prog_adr(prog_adr), .prog_data(prog_data), .wen(wen), .st(st),
    .dout(dout), .dout_oe(dout_oe)
  );

  mw_store #(.ADR16_W(ADR16_W), .PROG_CYCLES(PROG_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .org(org), .rd_adr(rd_adr),
    .rd_word(rd_word), .prog_req(prog_req), .prog_op(prog_op),
    .prog_adr(prog_adr), .prog_data(prog_data), .busy(busy)
  );
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
  import mw_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      cs,
  input logic      cs_q,
  input logic      dout,
  input logic      dout_oe,
  input logic      busy,
  input logic      wen,
  input logic      prog_req,
  input frame_st_t st
);
  AST_OE_AFTER_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs && $past(!cs, 1) && $past(!cs, 2)) |-> !dout_oe); // R7

  AST_BUSY_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen)); // R5

  AST_BUSY_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st == ST_IDLE) |=> st == ST_IDLE); // R11

  AST_ONE_PROG_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> !$past(busy)); // R11

  AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD && $past(st) != ST_RD) |-> (dout_oe && !dout)); // R6

  AST_PROG_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> $past(cs_q)); // R3
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .cs_q(cs_q), .dout(dout),
  .dout_oe(dout_oe), .busy(busy), .wen(wen), .prog_req(prog_req), .st(st)
);

// File: tb/mw_eeprom_test.sv
module mw_eeprom_test;
  localparam int HALF = 6;
  localparam int PROG = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sck = 1'b0, din = 1'b0, org = 1'b1;
  logic dout, dout_oe;
  int   checks = 0;
  int   errors = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  mw_eeprom uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .din(din), .org(org),
    .dout(dout), .dout_oe(dout_oe)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic o, output logic e);
    din = b;
    repeat (HALF) @(negedge clk);
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    o = dout;
    e = dout_oe;
    sck = 1'b0;
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    logic o, e;
    for (int i = n - 1; i >= 0; i--) bit_io(v[i], o, e);
  endtask

  task automatic cmd_begin();
    cs = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic cmd_end();
    cs = 1'b0;
    din = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic int aw();
    return org ? 6 : 7;
  endfunction

  function automatic int dw();
    return org ? 16 : 8;
  endfunction

  task automatic wait_ready();
    repeat (PROG + 20) @(negedge clk);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [15:0] d);
    cmd_begin();
    send_bits(16'b101, 3);
    send_bits({9'd0, a}, aw());
    send_bits(d, dw());
    cmd_end();
  endtask

  task automatic do_ext(input logic [1:0] code, input logic [15:0] d, input logic with_data);
    cmd_begin();
    send_bits(16'b100, 3);
    send_bits({14'd0, code}, 2);
    send_bits(16'd0, aw() - 2);
    if (with_data) send_bits(d, dw());
    cmd_end();
  endtask

  task automatic do_read(input logic [6:0] a, output logic [15:0] w,
                         output logic dz, output logic dzoe);
    logic o, e;
    cmd_begin();
    send_bits(16'b110, 3);
    for (int i = aw() - 1; i >= 0; i--) bit_io(a[i], o, e);
    dz = o;
    dzoe = e;
    w = '0;
    for (int i = 0; i < dw(); i++) begin
      bit_io(1'b0, o, e);
      w = {w[14:0], o};
    end
    cmd_end();
  endtask

  task automatic read_chk(input string tag, input logic [6:0] a, input logic [15:0] exp);
    logic [15:0] w;
    logic dz, dzoe;
    do_read(a, w, dz, dzoe);
    chk(tag, w, exp);
  endtask

  task automatic t_reset();
    chk("R12 oe low after reset", {15'd0, dout_oe}, 16'd0);
    read_chk("R12 storage erased after reset", 7'd20, 16'hFFFF);
  endtask

  task automatic t_locked();
    do_write(7'd5, 16'h1234);
    cmd_begin();
    chk("R5 no status after locked write", {15'd0, dout_oe}, 16'd0);
    cmd_end();
    read_chk("R5 locked write ignored", 7'd5, 16'hFFFF);
  endtask

  task automatic t_enable_write();
    logic [15:0] w;
    logic dz, dzoe;
    do_ext(2'b11, 16'd0, 1'b0);
    do_write(7'd5, 16'hA5C3);
    cmd_begin();
    chk("R8 status busy", {14'd0, dout_oe, dout}, 16'b10);
    wait_ready();
    chk("R8 status ready", {14'd0, dout_oe, dout}, 16'b11);
    cmd_end();
    chk("R7 oe off after cs low", {15'd0, dout_oe}, 16'd0);
    do_read(7'd5, w, dz, dzoe);
    chk("R6 dummy zero", {14'd0, dzoe, dz}, 16'b10);
    chk("R2 R6 x16 read data", w, 16'hA5C3);
  endtask

  task automatic t_busy();
    do_write(7'd6, 16'h1111);
    cmd_begin();
    send_bits(16'b110, 3);
    chk("R11 start refused while busy", {14'd0, dout_oe, dout}, 16'b10);
    cmd_end();
    wait_ready();
    read_chk("R11 write during busy window kept", 7'd6, 16'h1111);
  endtask

  task automatic t_abort();
    cmd_begin();
    send_bits(16'b101, 3);
    send_bits(16'd7, aw());
    send_bits(16'h3FF, 10);
    cmd_end();
    cmd_begin();
    chk("R3 aborted write no status", {15'd0, dout_oe}, 16'd0);
    cmd_end();
    read_chk("R3 aborted write no change", 7'd7, 16'hFFFF);
  endtask

  task automatic t_ignore();
    cmd_begin();
    send_bits(16'b101, 3);
    send_bits(16'd8, aw());
    send_bits(16'h0F0F, 16);
    send_bits(16'b101, 3);
    send_bits(16'd9, aw());
    send_bits(16'h0000, 16);
    cmd_end();
    wait_ready();
    read_chk("R4 trailing bits ignored", 7'd9, 16'hFFFF);
    read_chk("R4 first command stored", 7'd8, 16'h0F0F);
  endtask

  task automatic t_start();
    send_bits(16'b101, 3);
    send_bits(16'd10, aw());
    send_bits(16'h0000, 16);
    repeat (4) @(negedge clk);
    read_chk("R1 activity with cs low ignored", 7'd10, 16'hFFFF);
    cmd_begin();
    send_bits(16'b000, 3);
    send_bits(16'b101, 3);
    send_bits(16'd10, aw());
    send_bits(16'h2222, 16);
    cmd_end();
    wait_ready();
    read_chk("R1 leading zeros before start", 7'd10, 16'h2222);
  endtask

  task automatic t_erase();
    cmd_begin();
    send_bits(16'b111, 3);
    send_bits(16'd5, aw());
    cmd_end();
    wait_ready();
    read_chk("R9 erase gives all ones", 7'd5, 16'hFFFF);
  endtask

  task automatic t_all();
    do_ext(2'b01, 16'h5A5A, 1'b1);
    wait_ready();
    read_chk("R10 write-all word 0", 7'd0, 16'h5A5A);
    read_chk("R10 write-all word 63", 7'd63, 16'h5A5A);
    do_ext(2'b10, 16'd0, 1'b0);
    wait_ready();
    read_chk("R10 erase-all", 7'd8, 16'hFFFF);
    do_ext(2'b01, 16'h5A5A, 1'b1);
    wait_ready();
  endtask

  task automatic t_x8();
    org = 1'b0;
    repeat (4) @(negedge clk);
    do_write(7'h0B, 16'h003C);
    wait_ready();
    read_chk("R2 x8 read", 7'h0B, 16'h003C);
    read_chk("R2 x8 neighbour", 7'h0A, 16'h005A);
    org = 1'b1;
    repeat (4) @(negedge clk);
    read_chk("R2 x16 view of bytes", 7'd5, 16'h5A3C);
  endtask

  task automatic t_disable();
    do_ext(2'b00, 16'd0, 1'b0);
    do_write(7'd3, 16'hABCD);
    wait_ready();
    read_chk("R5 disable blocks write", 7'd3, 16'h5A5A);
  endtask

  task automatic t_cs_drop();
    cmd_begin();
    send_bits(16'b110, 3);
    send_bits(16'd3, aw());
    send_bits(16'd0, 2);
    chk("R7 oe on during read", {15'd0, dout_oe}, 16'd1);
    cs = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 oe off 3 clocks after cs fall", {15'd0, dout_oe}, 16'd0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_locked();
    t_enable_write();
    t_busy();
    t_abort();
    t_ignore();
    t_start();
    t_erase();
    t_all();
    t_x8();
    t_disable();
    t_cs_drop();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule